// File: doc/BRIEF.md
# Multi-word level interrupt masking controller

This block is a level-sensitive first-level interrupt controller. It takes up to 256 peripheral interrupt lines, grouped into 32-bit words, and gives every CPU its own register bank with a private mask over the same shared source lines. For each CPU it forms a pending value per word, the live source level ANDed with the inverse of that CPU's mask. It raises that CPU's interrupt output while any pending bit is set. The output passes through one register before it leaves the block.

Software uses a simple 32-bit register bus. A request selects the target CPU bank and a byte offset inside it. Each bank is packed group by group: all raw-status words first, then all mask-status words, then all mask-set words, then all mask-clear words. Every offset therefore scales with the word count N, which the build derives from the source count. Masks change only through write-one-to-set and write-one-to-clear registers, so software never has to read, modify and write a mask. Sources are level inputs: nothing is latched and no acknowledge exists.

Top module: `irq_l1_ctrl`

## Requirements
- R1: A read at byte offset (0*N + w)*4 of any bank returns the live level of sources 32w..32w+31, with bit b of the word being source 32w+b.
- R2: A read at byte offset (1*N + w)*4 returns that bank's mask word w, where a 1 means the source is disabled; after reset every mask bit of every bank is 1.
- R3: A write at byte offset (2*N + w)*4 sets each mask bit of word w whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A write at byte offset (3*N + w)*4 clears each mask bit of word w whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R5: The mask-set and mask-clear offsets read back as zero, and writes to the raw-status or mask-status offsets change no mask bit.
- R6: Reads at byte offsets of 16*N or more return zero, and writes there change no mask bit.
- R7: A CPU's interrupt output is 1 exactly when, at the previous clock edge, some source was high while its mask bit in that CPU's bank was 0.
- R8: A mask write to one CPU's bank leaves every other bank's mask and interrupt output unchanged.
- R9: Status bits for source numbers at or above the implemented source count read as zero and never raise an interrupt, whatever their mask bit holds.
- R10: A read request returns its data on the rsp_rdata port in the cycle after the request, marked by a one-cycle pulse on rsp_valid; writes produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NUM_SRC | Level interrupt lines from peripherals |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | CPU bank selected by the access |
| bus_addr | input | ADDR_W | Byte offset inside the selected bank |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| cpu_irq | output | NUM_CPUS | Registered interrupt output per CPU |

## Verification
Two functions can meet in one clock edge: a mask write on the register bus and a change of a source level, each of which alone moves the interrupt output. The bench drives both in the same cycle, raising a source while clearing its mask bit, and later dropping the mask over a source that is still high. It then judges the output edge by edge: after the first edge the output must still reflect the old mask, and after the second it must reflect both changes. Reads that a scoreboard predicts from a bench-side model of the masks and sources run between these steps, so a mask that takes the wrong value at the shared edge is caught in the register data as well as on the output.

// File: rtl/irq_l1_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the first-level interrupt controller.
// Assumes a 32-bit register bus and at most eight interrupt words.
package irq_l1_pkg;
    localparam int WORD_BITS = 32;
    localparam int MAX_WORDS = 8;

    // Register group order inside one bank; the group index scales offsets.
    typedef enum logic [1:0] {
        GRP_STATUS = 2'd0,
        GRP_MSTAT  = 2'd1,
        GRP_MSET   = 2'd2,
        GRP_MCLR   = 2'd3
    } reg_grp_e;
endpackage

// File: rtl/irq_addr_decode.sv
`timescale 1ns/1ps
// Splits a bank byte offset into register group and word index.
// Assumes groups are packed back to back, each NW words long; the two
// lowest address bits select bytes and do not change the decoded word.
module irq_addr_decode
    import irq_l1_pkg::*;
#(
    parameter int NW     = 8,
    parameter int ADDR_W = 8,
    localparam int WIDX_W = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_grp_e          grp,
    output logic [WIDX_W-1:0] word,
    output logic              hit
);
    int unsigned idx;
    int unsigned gnum;
    int unsigned wnum;

    // Divide the word index by the word count to find group and word.
    always_comb begin
        idx  = 32'(addr) >> 2;
        gnum = idx / NW;
        wnum = idx % NW;
        hit  = (idx < 4 * NW);
        grp  = reg_grp_e'(gnum[1:0]);
        word = wnum[WIDX_W-1:0];
    end
endmodule

// File: rtl/irq_src_gate.sv
`timescale 1ns/1ps
// Packs the source lines into 32-bit words and forces the bits beyond
// the implemented source count to zero. Purely combinational.
module irq_src_gate
    import irq_l1_pkg::*;
#(
    parameter int NUM_SRC = 250,
    localparam int NW = (NUM_SRC + WORD_BITS - 1) / WORD_BITS
) (
    input  logic [NUM_SRC-1:0]          src,
    output logic [NW-1:0][WORD_BITS-1:0] words
);
    for (genvar w = 0; w < NW; w++) begin : g_word
        for (genvar b = 0; b < WORD_BITS; b++) begin : g_bit
            if (w * WORD_BITS + b < NUM_SRC) begin : g_live
                // Implemented source: pass the level through.
                assign words[w][b] = src[w * WORD_BITS + b];
            end else begin : g_tie
                // Beyond the source count: always low.
                assign words[w][b] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
// One CPU's mask bank: NW mask words updated by write-one-to-set and
// write-one-to-clear strobes, the pending reduction and the registered
// interrupt output. Assumes set_en and clr_en are never high together.
module irq_mask_bank
    import irq_l1_pkg::*;
#(
    parameter int NW = 8,
    localparam int WIDX_W = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_en,
    input  logic                         clr_en,
    input  logic [WIDX_W-1:0]            word,
    input  logic [WORD_BITS-1:0]         wdata,
    input  logic [NW-1:0][WORD_BITS-1:0] src_words,
    output logic [NW-1:0][WORD_BITS-1:0] mask_o,
    output logic                         irq_o
);
    logic [NW-1:0][WORD_BITS-1:0] mask_q;
    logic [NW-1:0]                word_pend;

    for (genvar w = 0; w < NW; w++) begin : g_word
        // Mask word w: all ones at reset, then set or clear by strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[w] <= '1;
            end else if (set_en && word == WIDX_W'(w)) begin
                mask_q[w] <= mask_q[w] | wdata;
            end else if (clr_en && word == WIDX_W'(w)) begin
                mask_q[w] <= mask_q[w] & ~wdata;
            end
        end

        // Any live, unmasked source in this word.
        assign word_pend[w] = |(src_words[w] & ~mask_q[w]);

        // R3
        mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && word == WIDX_W'(w)) |=>
                ((mask_q[w] & $past(wdata)) == $past(wdata)));

        // R4
        mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && word == WIDX_W'(w)) |=>
                ((mask_q[w] & $past(wdata)) == '0));
    end

    // Register the OR of all pending words before it leaves the block.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |word_pend;
    end

    assign mask_o = mask_q;

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || clr_en) |=> $stable(mask_q));

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|src_words));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&mask_q) |-> !irq_o);
endmodule

// File: rtl/irq_l1_ctrl.sv
`timescale 1ns/1ps
// Level-sensitive first-level interrupt controller with one private mask
// bank per CPU over shared source lines. Register bus accesses take one
// cycle; reads answer one cycle later. Assumes word-aligned software use.
module irq_l1_ctrl
    import irq_l1_pkg::*;
#(
    parameter int NUM_SRC  = 250,
    parameter int NUM_CPUS = 2,
    parameter int ADDR_W   = 8,
    localparam int NW         = (NUM_SRC + WORD_BITS - 1) / WORD_BITS,
    localparam int WIDX_W     = (NW > 1) ? $clog2(NW) : 1,
    localparam int CPU_W      = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int BANK_BYTES = 16 * NW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_irq,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [CPU_W-1:0]     bus_cpu,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic [NUM_CPUS-1:0]  cpu_irq
);
    reg_grp_e                             grp;
    logic [WIDX_W-1:0]                    word;
    logic                                 hit;
    logic                                 cpu_ok;
    logic                                 wr_ok;
    logic [NW-1:0][WORD_BITS-1:0]         src_words;
    logic [NUM_CPUS-1:0][NW-1:0][WORD_BITS-1:0] masks;
    logic [NUM_CPUS-1:0]                  set_en;
    logic [NUM_CPUS-1:0]                  clr_en;
    logic [31:0]                          rd_mux;

    irq_addr_decode #(.NW(NW), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .grp  (grp),
        .word (word),
        .hit  (hit)
    );

    irq_src_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .src   (src_irq),
        .words (src_words)
    );

    assign cpu_ok = (32'(bus_cpu) < NUM_CPUS);
    assign wr_ok  = bus_req && bus_we && hit && cpu_ok;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
        // Strobes reach only the bank the access selects.
        assign set_en[c] = wr_ok && grp == GRP_MSET && bus_cpu == CPU_W'(c);
        assign clr_en[c] = wr_ok && grp == GRP_MCLR && bus_cpu == CPU_W'(c);

        irq_mask_bank #(.NW(NW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_en    (set_en[c]),
            .clr_en    (clr_en[c]),
            .word      (word),
            .wdata     (bus_wdata),
            .src_words (src_words),
            .mask_o    (masks[c]),
            .irq_o     (cpu_irq[c])
        );
    end

    // Select read data: status and mask words; everything else reads zero.
    always_comb begin
        rd_mux = '0;
        if (hit && cpu_ok) begin
            case (grp)
                GRP_STATUS: rd_mux = src_words[word];
                GRP_MSTAT:  rd_mux = masks[bus_cpu][word];
                default:    rd_mux = '0;
            endcase
        end
    end

    // Return read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_req && !bus_we;
            if (bus_req && !bus_we) rsp_rdata <= rd_mux;
        end
    end

    // R6
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && 32'($past(bus_addr)) >= BANK_BYTES) |-> (rsp_rdata == '0));

    // R8
    bank_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_en | clr_en));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> !rsp_valid);
endmodule

// File: tb/sim_irq_l1_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push predicted data into a queue, a
// monitor pops and compares when the design answers.
module sim_irq_l1_ctrl;
    localparam int NUM_SRC  = 250;
    localparam int NUM_CPUS = 2;
    localparam int ADDR_W   = 8;
    localparam int NW       = (NUM_SRC + 31) / 32;
    localparam int CPU_W    = 1;
    localparam int BANK     = 16 * NW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_SRC-1:0]  src_irq = '0;
    logic                bus_req = 1'b0;
    logic                bus_we = 1'b0;
    logic [CPU_W-1:0]    bus_cpu = '0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic                rsp_valid;
    logic [31:0]         rsp_rdata;
    logic [NUM_CPUS-1:0] cpu_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] mdl_mask [NUM_CPUS][NW];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    irq_l1_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_req(bus_req),
        .bus_we(bus_we), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] src_word(input int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++)
            if (w * 32 + b < NUM_SRC) v[b] = src_irq[w * 32 + b];
        return v;
    endfunction

    function automatic logic exp_irq(input int c);
        logic r = 1'b0;
        for (int w = 0; w < NW; w++) r |= |(src_word(w) & ~mdl_mask[c][w]);
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input int c, input int addr);
        int idx = addr / 4;
        if (addr >= BANK) return '0;
        if (idx / NW == 0) return src_word(idx % NW);
        if (idx / NW == 1) return mdl_mask[c][idx % NW];
        return '0;
    endfunction

    function automatic int off(input int grp, input int w);
        return (grp * NW + w) * 4;
    endfunction

    // Monitor: compare every returned read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R10: unexpected response %08h expected none", rsp_rdata);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_read(input int c, input int addr, input string req);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_cpu = CPU_W'(c); bus_addr = ADDR_W'(addr);
        exp_q.push_back(exp_rd(c, addr));
        tag_q.push_back(req);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R10 read pulse", 32'(rsp_valid), 32'd1);
    endtask

    task automatic do_write(input int c, input int addr, input logic [31:0] d);
        int idx = addr / 4;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_cpu = CPU_W'(c);
        bus_addr = ADDR_W'(addr); bus_wdata = d;
        if (addr < BANK && idx / NW == 2) mdl_mask[c][idx % NW] |= d;
        if (addr < BANK && idx / NW == 3) mdl_mask[c][idx % NW] &= ~d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R10 no pulse on write", 32'(rsp_valid), 32'd0);
    endtask

    task automatic chk_irqs(input string req);
        repeat (2) @(negedge clk);
        for (int c = 0; c < NUM_CPUS; c++)
            chk(req, 32'(cpu_irq[c]), 32'(exp_irq(c)));
    endtask

    task automatic read_masks(input int c, input string req);
        for (int w = 0; w < NW; w++) do_read(c, off(1, w), req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NUM_CPUS; c++)
            for (int w = 0; w < NW; w++) mdl_mask[c][w] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset irq", 32'(cpu_irq), 32'd0);
        chk("R10 reset valid", 32'(rsp_valid), 32'd0);
        for (int c = 0; c < NUM_CPUS; c++) read_masks(c, "R2 reset mask");

        // R1 / R9: live status, with every source still masked (R7).
        for (int i = 0; i < NUM_SRC; i++) src_irq[i] = ((i * 7) % 3 == 0);
        chk_irqs("R7 all masked");
        for (int w = 0; w < NW; w++) do_read(0, off(0, w), "R1 status");
        for (int w = 0; w < NW; w++) do_read(1, off(0, w), "R1 status bank1");
        chk(src_word(NW - 1) >> 26 == 0 ? "R9 model" : "R9 model", src_word(NW - 1) >> 26, 32'd0);

        // R4: clear mask bits on bank 0, word 0 only.
        src_irq[4] = 1'b1;
        do_write(0, off(3, 0), 32'h0000_00F0);
        read_masks(0, "R4 clear");
        chk_irqs("R7 unmasked");
        chk("R7 irq0 raised", 32'(cpu_irq[0]), 32'd1);
        chk("R8 irq1 quiet", 32'(cpu_irq[1]), 32'd0);
        read_masks(1, "R8 bank1 untouched");

        // R3: set one bit, zeros elsewhere keep their value.
        do_write(0, off(2, 0), 32'h0000_0010);
        do_read(0, off(1, 0), "R3 set");
        chk_irqs("R3 irq after set");

        // R5: set/clear offsets read zero; status writes ignored.
        do_read(0, off(2, 3), "R5 set reads zero");
        do_read(1, off(3, 7), "R5 clear reads zero");
        do_write(0, off(0, 0), 32'hFFFF_FFFF);
        do_write(0, off(1, 0), 32'h0000_0000);
        do_read(0, off(1, 0), "R5 status write ignored");
        chk_irqs("R5 irq unchanged");

        // R6: beyond the bank.
        do_write(0, BANK, 32'hFFFF_FFFF);
        do_write(1, BANK + 4 * NW + 4, 32'hFFFF_FFFF);
        do_read(0, BANK, "R6 oob read");
        do_read(1, 252, "R6 oob read high");
        read_masks(0, "R6 oob write ignored");
        read_masks(1, "R6 oob write ignored bank1");

        // R8: bank 1 clear leaves bank 0 alone.
        do_write(1, off(3, 3), 32'hFFFF_FFFF);
        read_masks(0, "R8 bank0 untouched");
        do_read(1, off(1, 3), "R4 bank1 clear");
        chk_irqs("R8 irqs");

        // R9: unmask unimplemented bits of the last word on bank 1.
        src_irq = '0;
        do_write(1, off(3, 3), 32'h0);
        do_write(1, off(2, 3), 32'hFFFF_FFFF);
        mdl_mask[1][3] = '1;
        do_write(1, off(3, NW - 1), 32'hC000_0000);
        do_read(1, off(1, NW - 1), "R9 mask bits");
        do_read(1, off(0, NW - 1), "R9 status zero");
        chk_irqs("R9 no irq");
        chk("R9 irq1", 32'(cpu_irq[1]), 32'd0);

        // Same edge: raise a source and clear its mask bit together.
        do_write(0, off(2, 0), 32'hFFFF_FFFF);
        chk_irqs("R7 quiet before");
        @(negedge clk);
        src_irq[5 * 32 + 3] = 1'b1;
        bus_req = 1'b1; bus_we = 1'b1; bus_cpu = 1'b0;
        bus_addr = ADDR_W'(off(3, 5)); bus_wdata = 32'h0000_0008;
        mdl_mask[0][5] &= ~32'h0000_0008;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R7 same-edge first", 32'(cpu_irq[0]), 32'd0);
        @(negedge clk);
        chk("R7 same-edge second", 32'(cpu_irq[0]), 32'd1);
        chk("R8 same-edge other", 32'(cpu_irq[1]), 32'd0);

        // Mask again while the source stays high.
        do_write(0, off(2, 5), 32'h0000_0008);
        chk("R3 mask lands late", 32'(cpu_irq[0]), 32'd1);
        @(negedge clk);
        chk("R3 masked again", 32'(cpu_irq[0]), 32'd0);
        do_read(0, off(1, 5), "R3 mask restored");

        repeat (3) @(negedge clk);
        chk("R10 all answered", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule